// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing datapath. Each cycle it can take two 16-bit operands, multiply them in a 17-by-17 signed multiplier and then load, add or subtract the product into one of two 40-bit accumulators. It can also shift the chosen accumulator by up to 16 places in either direction, or clear it. Eight guard bits above the 32-bit working range absorb growth over long sums. Per operation, the result can wrap, clamp to the 32-bit fractional range, or clamp to the full 40-bit range.

Each operand is zero-extended or sign-extended to 17 bits, as its own signedness control selects. In fractional mode the product is doubled, so 1.15 operands give a 1.31 result. The one product that cannot be represented, minus one times minus one, becomes the largest positive 1.31 value. Every accumulator has three flags. The first is a live guard flag. The second records, until the next clear, that a result overflowed the 40-bit range. The third records, until the next clear, that a result was clamped.

Top module: `sat_mac_engine`

## Requirements
- R1: After reset both accumulators read zero and all flags are low.
- R2: The `op` field is decoded as 0 idle, 1 multiply-accumulate, 2 multiply-subtract, 3 multiply-load, 4 shift, 5 clear; codes 6 and 7 change nothing. The result of an operation is visible on the outputs after the next rising clock edge. Only the accumulator picked by `acc_sel` (0 selects the first accumulator, 1 the second) changes.
- R3: Multiply-subtract removes the product from the selected accumulator.
- R4: Multiply-load replaces the accumulator with the product. Each operand is sign-extended to 17 bits when its own signed control is high, and zero-extended otherwise.
- R5: With `frac_mode` high the product is doubled before use. When both operands are signed and both equal 0x8000, the product is 0x007FFFFFFF instead.
- R6: A guard flag is high exactly when bits 39 down to 31 of its accumulator are not all equal.
- R7: When the exact result does not fit in 40-bit two's complement, the overflow flag of that accumulator is set and stays set until a clear. Without saturation the low 40 bits of the exact result are kept.
- R8: With `sat_en` high and `super_en` low, a result outside the 32-bit signed range is clamped to 0x007FFFFFFF or 0xFF80000000, and the sticky clamp flag is set.
- R9: With `super_en` high, only results outside the 40-bit range are clamped, to 0x7FFFFFFFFF or 0x8000000000, and the sticky clamp flag is set. This mode takes precedence over `sat_en`.
- R10: Shift reads `shift_amt` as 6-bit two's complement. A positive value shifts the accumulator arithmetically right and a negative value shifts it left. The result passes through the same overflow and saturation rules.
- R11: A shift amount below -16 or above +16 leaves both accumulators and all flags unchanged.
- R12: Clear sets the selected accumulator and its overflow and clamp flags to zero in one cycle.
- R13: While `in_valid` is low, no accumulator or flag changes, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe (clock enable) |
| op | input | 3 | Operation code |
| acc_sel | input | 1 | Accumulator select |
| opa | input | 16 | First multiplier operand |
| opb | input | 16 | Second multiplier operand |
| a_signed | input | 1 | Sign-extend `opa` |
| b_signed | input | 1 | Sign-extend `opb` |
| frac_mode | input | 1 | Double the product |
| shift_amt | input | 6 | Signed shift amount |
| sat_en | input | 1 | 32-bit range saturation |
| super_en | input | 1 | 40-bit range saturation |
| acc_q | output | 80 | Accumulators; first in bits 39:0 |
| guard_ovf | output | 2 | Guard-bit flags, one per accumulator |
| cat_ovf | output | 2 | Sticky 40-bit overflow flags |
| sat_hit | output | 2 | Sticky clamp flags |

## Verification
The bench works through every pairing of a set of edge operands, in all signedness combinations, with fractional mode both on and off. A wrong operand extension, a missed doubling or a mishandled minus-one squared shows up there as a wrong loaded value. It drives long runs of large products up past the 40-bit limit and back down past the negative limit under each saturation mode. A clamp at the wrong threshold, a sign error on the way back, or an overflow flag that drops would all be caught on those runs. It also sweeps all 64 shift codes over positive and negative values. A design that read the amount as unsigned, did not sign-fill on a right shift, or acted on out-of-range codes would leave a wrong accumulator there.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_MAC   = 3'd1,
    OP_MSC   = 3'd2,
    OP_MPY   = 3'd3,
    OP_SHIFT = 3'd4,
    OP_CLR   = 3'd5
  } mac_op_e;
endpackage

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          a_signed,
  input  logic          b_signed,
  input  logic          frac,
  output logic [AW-1:0] prod
);
  localparam int EW = DW + 1;
  localparam int MW = 2 * EW;
  localparam logic [DW-1:0] MINUS_ONE = {1'b1, {(DW-1){1'b0}}};
  localparam logic [AW-1:0] FRAC_MAX  = {{(AW-2*DW+1){1'b0}}, {(2*DW-1){1'b1}}};

  logic signed [EW-1:0] ea, eb;
  logic signed [MW-1:0] raw;
  logic        [MW:0]   scaled;
  logic                 corner;

  assign ea     = {a_signed & a[DW-1], a};
  assign eb     = {b_signed & b[DW-1], b};
  assign raw    = ea * eb;
  assign scaled = frac ? {raw, 1'b0} : {raw[MW-1], raw};
  assign corner = frac & a_signed & b_signed & (a == MINUS_ONE) & (b == MINUS_ONE);

  always_comb begin
    if (corner) prod = FRAC_MAX;
    else        prod = {{(AW-MW-1){scaled[MW]}}, scaled};
  end
endmodule

// File: rtl/mac_barrel_shift.sv
module mac_barrel_shift #(
  parameter int AW   = 40,
  parameter int SHW  = 6,
  parameter int MAXS = 16
) (
  input  logic [AW-1:0]      acc,
  input  logic [SHW-1:0]     amt,
  output logic [AW+MAXS-1:0] wide,
  output logic               in_range
);
  localparam int WW = AW + MAXS;

  logic signed [WW-1:0] ext;
  logic        [SHW-1:0] mag;
  int                    sv;

  assign sv       = int'($signed(amt));
  assign in_range = (sv <= MAXS) && (sv >= -MAXS);
  assign mag      = amt[SHW-1] ? (~amt + 1'b1) : amt;
  assign ext      = {{MAXS{acc[AW-1]}}, acc};

  always_comb begin
    if (!in_range)       wide = ext;
    else if (amt[SHW-1]) wide = ext << mag;
    else                 wide = ext >>> mag;
  end
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate #(
  parameter int AW = 40,
  parameter int WW = 56,
  parameter int GW = 32
) (
  input  logic [WW-1:0] ideal,
  input  logic          sat_en,
  input  logic          super_en,
  output logic [AW-1:0] res,
  output logic          catastrophic,
  output logic          clamped
);
  logic fits_full, fits_work, neg;

  assign neg          = ideal[WW-1];
  assign fits_full    = (&ideal[WW-1:AW-1]) | ~(|ideal[WW-1:AW-1]);
  assign fits_work    = (&ideal[WW-1:GW-1]) | ~(|ideal[WW-1:GW-1]);
  assign catastrophic = ~fits_full;

  always_comb begin
    res     = ideal[AW-1:0];
    clamped = 1'b0;
    if (super_en) begin
      if (!fits_full) begin
        res     = neg ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
        clamped = 1'b1;
      end
    end else if (sat_en && !fits_work) begin
      res     = neg ? {{(AW-GW+1){1'b1}}, {(GW-1){1'b0}}}
                    : {{(AW-GW+1){1'b0}}, {(GW-1){1'b1}}};
      clamped = 1'b1;
    end
  end
endmodule

// File: rtl/sat_mac_engine.sv
module sat_mac_engine #(
  parameter int DW   = 16,
  parameter int AW   = 40,
  parameter int GW   = 32,
  parameter int SHW  = 6,
  parameter int MAXS = 16,
  parameter int NACC = 2,
  parameter int SELW = (NACC > 1) ? $clog2(NACC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          op,
  input  logic [SELW-1:0]     acc_sel,
  input  logic [DW-1:0]       opa,
  input  logic [DW-1:0]       opb,
  input  logic                a_signed,
  input  logic                b_signed,
  input  logic                frac_mode,
  input  logic [SHW-1:0]      shift_amt,
  input  logic                sat_en,
  input  logic                super_en,
  output logic [NACC*AW-1:0]  acc_q,
  output logic [NACC-1:0]     guard_ovf,
  output logic [NACC-1:0]     cat_ovf,
  output logic [NACC-1:0]     sat_hit
);
  import sat_mac_pkg::*;
  localparam int WW = AW + MAXS;

  mac_op_e       op_e;
  logic [AW-1:0] acc_v [NACC];
  logic [AW-1:0] cur, prod, res;
  logic [AW:0]   sum;
  logic [WW-1:0] wide, ideal;
  logic          sh_ok, cat_now, clamp_now, upd, clr;

  assign op_e = mac_op_e'(op);
  assign cur  = acc_v[acc_sel];

  mac_multiplier #(.DW(DW), .AW(AW)) u_mul (
    .a(opa), .b(opb), .a_signed(a_signed), .b_signed(b_signed),
    .frac(frac_mode), .prod(prod)
  );

  mac_barrel_shift #(.AW(AW), .SHW(SHW), .MAXS(MAXS)) u_shift (
    .acc(cur), .amt(shift_amt), .wide(wide), .in_range(sh_ok)
  );

  assign sum = (op_e == OP_MSC) ? ({cur[AW-1], cur} - {prod[AW-1], prod})
                                : ({cur[AW-1], cur} + {prod[AW-1], prod});

  always_comb begin
    case (op_e)
      OP_MPY:   ideal = {{(WW-AW){prod[AW-1]}}, prod};
      OP_SHIFT: ideal = wide;
      default:  ideal = {{(WW-AW-1){sum[AW]}}, sum};
    endcase
  end

  mac_saturate #(.AW(AW), .WW(WW), .GW(GW)) u_sat (
    .ideal(ideal), .sat_en(sat_en), .super_en(super_en),
    .res(res), .catastrophic(cat_now), .clamped(clamp_now)
  );

  always_comb begin
    case (op_e)
      OP_MAC, OP_MSC, OP_MPY: upd = in_valid;
      OP_SHIFT:               upd = in_valid & sh_ok;
      default:                upd = 1'b0;
    endcase
    clr = in_valid & (op_e == OP_CLR);
  end

  for (genvar gi = 0; gi < NACC; gi++) begin : g_acc
    logic [AW-1:0] acc_r, acc_d;
    logic          cat_r, cat_d, sat_r, sat_d;
    logic          hit, en;

    assign hit = (acc_sel == SELW'(gi));
    assign en  = hit & (upd | clr);

    always_comb begin
      acc_d = acc_r;
      cat_d = cat_r;
      sat_d = sat_r;
      if (clr) begin
        acc_d = '0;
        cat_d = 1'b0;
        sat_d = 1'b0;
      end else if (upd) begin
        acc_d = res;
        cat_d = cat_r | cat_now;
        sat_d = sat_r | clamp_now;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_r <= '0;
        cat_r <= 1'b0;
        sat_r <= 1'b0;
      end else if (en) begin
        acc_r <= acc_d;
        cat_r <= cat_d;
        sat_r <= sat_d;
      end
    end

    assign acc_v[gi]              = acc_r;
    assign acc_q[gi*AW +: AW]     = acc_r;
    assign cat_ovf[gi]            = cat_r;
    assign sat_hit[gi]            = sat_r;
    assign guard_ovf[gi]          = ~((&acc_r[AW-1:GW-1]) | ~(|acc_r[AW-1:GW-1]));
  end
endmodule

// File: rtl/sat_mac_checker.sv
module sat_mac_checker #(
  parameter int AW   = 40,
  parameter int SHW  = 6,
  parameter int MAXS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [2:0]      op,
  input logic            acc_sel,
  input logic [SHW-1:0]  shift_amt,
  input logic            sat_en,
  input logic            super_en,
  input logic [2*AW-1:0] acc_q,
  input logic [1:0]      guard_ovf,
  input logic [1:0]      cat_ovf,
  input logic [1:0]      sat_hit
);
  logic sh_oor;
  assign sh_oor = (int'($signed(shift_amt)) > MAXS) || (int'($signed(shift_amt)) < -MAXS);

  p_clear_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd5 && !acc_sel) |=> (acc_q[AW-1:0] == '0 && !cat_ovf[0] && !sat_hit[0]));

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc_q) && $stable(cat_ovf) && $stable(sat_hit)));

  p_unsel_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !acc_sel) |=> ($stable(acc_q[2*AW-1:AW]) && $stable(cat_ovf[1]) && $stable(sat_hit[1])));

  p_normal_sat_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 3'd1 || op == 3'd2 || op == 3'd3) && sat_en && !super_en && !acc_sel)
      |=> !guard_ovf[0]);

  p_cat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cat_ovf[0] && !(in_valid && op == 3'd5 && !acc_sel)) |=> cat_ovf[0]);

  p_shift_oor_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd4 && sh_oor) |=> ($stable(acc_q) && $stable(cat_ovf) && $stable(sat_hit)));
endmodule

bind sat_mac_engine sat_mac_checker #(.AW(AW), .SHW(SHW), .MAXS(MAXS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc_sel(acc_sel),
  .shift_amt(shift_amt), .sat_en(sat_en), .super_en(super_en), .acc_q(acc_q),
  .guard_ovf(guard_ovf), .cat_ovf(cat_ovf), .sat_hit(sat_hit)
);

// File: tb/sat_mac_engine_bench.sv
module sat_mac_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic        acc_sel;
  logic [15:0] opa, opb;
  logic        a_signed, b_signed, frac_mode, sat_en, super_en;
  logic [5:0]  shift_amt;
  logic [79:0] acc_q;
  logic [1:0]  guard_ovf, cat_ovf, sat_hit;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  longint ma [2];
  bit     mcat [2];
  bit     msat [2];

  always #10 clk = ~clk;

  sat_mac_engine u_sat_mac_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc_sel(acc_sel),
    .opa(opa), .opb(opb), .a_signed(a_signed), .b_signed(b_signed),
    .frac_mode(frac_mode), .shift_amt(shift_amt), .sat_en(sat_en),
    .super_en(super_en), .acc_q(acc_q), .guard_ovf(guard_ovf),
    .cat_ovf(cat_ovf), .sat_hit(sat_hit)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit fits(input longint v, input int bits);
    longint lim;
    lim = longint'(1) <<< (bits - 1);
    return (v >= -lim) && (v <= lim - 1);
  endfunction

  task automatic compare_all(input string tag);
    for (int i = 0; i < 2; i++) begin
      logic [39:0] exp_v;
      logic [2:0]  exp_f, act_f;
      exp_v = ma[i][39:0];
      chk(acc_q[i*40 +: 40] == exp_v, tag, longint'(acc_q[i*40 +: 40]), longint'(exp_v));
      exp_f = {!fits(ma[i], 32), mcat[i], msat[i]};
      act_f = {guard_ovf[i], cat_ovf[i], sat_hit[i]};
      chk(act_f == exp_f, {tag, " flags"}, longint'(act_f), longint'(exp_f));
    end
  endtask

  task automatic do_op(input logic [2:0] o, input int sel, input logic [15:0] a, input logic [15:0] b,
                       input logic as, input logic bs, input logic fr, input logic [5:0] sh,
                       input logic se, input logic ss, input logic vld, input string tag);
    longint ea, eb, p, cur, ideal, res;
    bit upd, clr, clampd;
    int s;
    in_valid = vld; op = o; acc_sel = sel[0]; opa = a; opb = b;
    a_signed = as; b_signed = bs; frac_mode = fr; shift_amt = sh;
    sat_en = se; super_en = ss;
    ea = as ? longint'($signed(a)) : longint'(a);
    eb = bs ? longint'($signed(b)) : longint'(b);
    p  = ea * eb;
    if (fr) begin
      if (as && bs && a == 16'h8000 && b == 16'h8000) p = 64'sd2147483647;
      else p = p * 2;
    end
    cur = ma[sel]; ideal = 0; upd = 0; clr = 0;
    s = int'($signed(sh));
    if (vld) begin
      case (o)
        3'd1: begin ideal = cur + p; upd = 1; end
        3'd2: begin ideal = cur - p; upd = 1; end
        3'd3: begin ideal = p; upd = 1; end
        3'd4: if (s >= -16 && s <= 16) begin
                upd = 1;
                ideal = (s >= 0) ? (cur >>> s) : (cur <<< (-s));
              end
        3'd5: clr = 1;
        default: ;
      endcase
    end
    if (clr) begin
      ma[sel] = 0; mcat[sel] = 0; msat[sel] = 0;
    end else if (upd) begin
      clampd = 0;
      if (ss && !fits(ideal, 40)) begin
        res = (ideal < 0) ? -(longint'(1) <<< 39) : (longint'(1) <<< 39) - 1; clampd = 1;
      end else if (se && !ss && !fits(ideal, 32)) begin
        res = (ideal < 0) ? -(longint'(1) <<< 31) : (longint'(1) <<< 31) - 1; clampd = 1;
      end else begin
        res = longint'($signed(ideal[39:0]));
      end
      ma[sel] = res;
      mcat[sel] = mcat[sel] | !fits(ideal, 40);
      msat[sel] = msat[sel] | clampd;
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    logic [15:0] vals [8];
    vals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234, 16'hC000, 16'h0003};
    for (int i = 0; i < 2; i++) begin ma[i] = 0; mcat[i] = 0; msat[i] = 0; end
    rst_n = 1'b0; in_valid = 1'b0; op = 3'd0; acc_sel = 1'b0; opa = '0; opb = '0;
    a_signed = 1'b0; b_signed = 1'b0; frac_mode = 1'b0; shift_amt = '0;
    sat_en = 1'b0; super_en = 1'b0;
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    // R4/R5 multiply-load sweep over operand pairs, signedness and fractional mode
    for (int m = 0; m < 16; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          do_op(3'd3, (i + j) % 2, vals[i], vals[j], m[0], m[1], m[2], 6'd0, m[3], 1'b0, 1'b1,
                m[2] ? "R5 frac load" : "R4 load");

    // R2/R3/R7/R8/R9 long accumulation runs under each saturation mode
    for (int mode = 0; mode < 3; mode++) begin
      do_op(3'd5, 0, 16'h0, 16'h0, 0, 0, 0, 6'd0, 0, 0, 1'b1, "R12 clear");
      for (int k = 0; k < 300; k++)
        do_op(3'd1, 0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 6'd0, mode == 1, mode == 2, 1'b1,
              mode == 0 ? "R7 MAC wrap" : (mode == 1 ? "R8 MAC sat" : "R9 MAC supersat"));
      for (int k = 0; k < 600; k++)
        do_op(3'd2, 0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 6'd0, mode == 1, mode == 2, 1'b1,
              mode == 0 ? "R3 MSC wrap" : (mode == 1 ? "R8 MSC sat" : "R9 MSC supersat"));
      do_op(3'd1, 1, 16'h0100, 16'h0200, 1, 1, 0, 6'd0, 0, 0, 1'b1, "R2 MAC other acc");
    end

    // R10/R11 full sweep of shift codes
    for (int mode = 0; mode < 3; mode++)
      for (int st = 0; st < 3; st++)
        for (int c = 0; c < 64; c++) begin
          logic [15:0] la, lb;
          la = (st == 0) ? 16'h1234 : ((st == 1) ? 16'h8001 : 16'h0005);
          lb = (st == 0) ? 16'h5678 : ((st == 1) ? 16'h7FFF : 16'h0003);
          do_op(3'd3, 1, la, lb, 1, 1, st == 1, 6'd0, 0, 0, 1'b1, "R4 shift preload");
          do_op(3'd4, 1, 16'h0, 16'h0, 0, 0, 0, 6'(c), mode == 1, mode == 2, 1'b1,
                (c > 16 && c < 48) ? "R11 shift out of range" : "R10 shift");
        end

    // R13 idle strobe and R2 unused codes
    do_op(3'd3, 0, 16'h4000, 16'h4000, 1, 1, 1, 6'd0, 0, 0, 1'b1, "R4 load");
    do_op(3'd1, 0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 6'd0, 0, 0, 1'b0, "R13 idle MAC");
    do_op(3'd5, 0, 16'h0, 16'h0, 0, 0, 0, 6'd0, 0, 0, 1'b0, "R13 idle clear");
    do_op(3'd6, 0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 6'd0, 0, 0, 1'b1, "R2 code 6");
    do_op(3'd7, 0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 6'd0, 0, 0, 1'b1, "R2 code 7");
    do_op(3'd0, 0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 6'd0, 0, 0, 1'b1, "R2 idle code");
    do_op(3'd5, 1, 16'h0, 16'h0, 0, 0, 0, 6'd0, 0, 0, 1'b1, "R12 clear second");
    do_op(3'd5, 0, 16'h0, 16'h0, 0, 0, 0, 6'd0, 0, 0, 1'b1, "R12 clear first");
    do_op(3'd3, 0, 16'hFFFF, 16'hFFFF, 0, 0, 1, 6'd0, 0, 0, 1'b1, "R6 guard from unsigned");

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule